// File: doc/BRIEF.md
# Reset Cause and System Option Register Block

This block sits in the system controller of a small microcontroller. It turns reset requests from several sources into one stretched reset-request output, records which source or sources caused the reset that is in progress, and holds a system-options byte that software may set exactly once per reset.

Three sources can start a reset while the chip is running. The first is the clock-generation module. The second is the low-voltage comparator, but only when both low-voltage enables are on. The third is a debug host, which writes a 1 into the force bit over a dedicated debug write strobe. Writes to the force-reset location from the ordinary CPU bus do nothing. The block's own asynchronous power-on reset counts as a fourth source.

While the reset-request output is active, the options register is held at its defined value and its lock is cleared. Once the request ends, the first CPU write to the options register is honoured and locks it. Every later write is dropped until the next reset.

Top module: `rst_cause_sysopt`

## Requirements
- R1: After power-on reset (`por_n` low), the status register (CPU address 0) reads 0x82: bit 7 marks power-on and bit 1 marks low voltage. All other bits read 0.
- R2: A one-cycle `clkgen_req` outside a reset sets status to 0x04 (bit 2 only). Every earlier cause bit is cleared.
- R3: A low-voltage reset starts only when `lv_below`, `lvd_en` and `lvd_rst_en` are all 1. It sets status to 0x02. Any other combination leaves the status and `sys_rst_req` unchanged.
- R4: A debug write (`dbg_wr`) with `dbg_wbit` = 1 starts a reset and sets status to 0x08 (bit 3). With `dbg_wbit` = 0 it has no effect.
- R5: The force-reset location (CPU address 1) always reads 0x00. CPU writes to it never start a reset.
- R6: Causes that arrive in the same cycle set all of their status bits together. A cause that arrives while a reset is already in progress ORs its bit into the status.
- R7: `sys_rst_req` stays high for exactly PULSE_LEN (16) cycles after the last cycle in which a cause was active, and also after power-on release. A new cause restarts the full window.
- R8: The options register (CPU address 2) resets to 0xF3. Bits 3 and 2 always read 0.
- R9: The first CPU write to address 2 after a reset ends stores the written data with bits 3:2 cleared. Every later write is ignored.
- R10: Any reset returns the options register to 0xF3 and unlocks it. Writes made while `sys_rst_req` is high are ignored.
- R11: CPU writes to the status address leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| clkgen_req | input | 1 | Reset request from the clock-generation module |
| lv_below | input | 1 | Low-voltage comparator output: supply below trip level |
| lvd_en | input | 1 | Low-voltage detector enable |
| lvd_rst_en | input | 1 | Low-voltage reset enable |
| dbg_wr | input | 1 | Debug-path write strobe to the force-reset location |
| dbg_wbit | input | 1 | Data bit 0 of the debug write |
| cpu_sel | input | 1 | CPU register access select |
| cpu_wr | input | 1 | CPU write enable |
| cpu_addr | input | 2 | Register address: 0 status, 1 force reset, 2 options |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address |
| sys_rst_req | output | 1 | Stretched system reset request |

## Verification
CPU read data is combinational, so the bench checks it within the same cycle, just after setting the address. A cause held across one rising edge appears in the status and on `sys_rst_req` at the next sample. The bench then counts the samples during which the request stays high and expects exactly 16. An options write takes effect at the edge that ends the write cycle, and the bench reads the register back in the following cycle. Inputs are driven and outputs sampled on the falling clock edge, so every check lands one full register stage after its stimulus.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ADR_STATUS = 2'd0,
    ADR_FORCE  = 2'd1,
    ADR_OPTS   = 2'd2,
    ADR_NONE   = 2'd3
  } rcs_addr_e;

  // status bit positions
  localparam int unsigned ST_POR = 7;
  localparam int unsigned ST_DBG = 3;
  localparam int unsigned ST_CLK = 2;
  localparam int unsigned ST_LV  = 1;

  typedef struct packed {
    logic dbg;
    logic clk;
    logic lv;
  } rcs_cause_t;

  function automatic logic [BYTE_W-1:0] status_of(input rcs_cause_t c);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_DBG] = c.dbg;
    s[ST_CLK] = c.clk;
    s[ST_LV]  = c.lv;
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] por_status();
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_POR] = 1'b1;
    s[ST_LV]  = 1'b1;
    return s;
  endfunction

  function automatic logic lv_trip(input logic below, input logic en, input logic rst_en);
    return below & en & rst_en;
  endfunction

endpackage

// File: rtl/rcs_pulse_stretch.sv
module rcs_pulse_stretch #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOADV = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= LOADV;
    end else if (trig) begin
      cnt_q <= LOADV;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/rcs_cause_latch.sv
module rcs_cause_latch
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  rcs_cause_t         causes,
  input  logic               in_reset,
  output logic [BYTE_W-1:0]  status
);
  logic [BYTE_W-1:0] status_q;
  logic              any_cause;

  assign any_cause = |causes;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status_q <= por_status();
    end else if (any_cause) begin
      status_q <= (in_reset ? status_q : '0) | status_of(causes);
    end
  end

  assign status = status_q;
endmodule

// File: rtl/rcs_opt_reg.sv
module rcs_opt_reg #(
  parameter logic [7:0] RST_VAL  = 8'hF3,
  parameter logic [7:0] IMPL_MSK = 8'hF3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       clear,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] opt,
  output logic       locked
);
  localparam logic [7:0] RST_EFF = RST_VAL & IMPL_MSK;

  logic [7:0] opt_q;
  logic       lock_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opt_q  <= RST_EFF;
      lock_q <= 1'b0;
    end else if (clear) begin
      opt_q  <= RST_EFF;
      lock_q <= 1'b0;
    end else if (wr_en && !lock_q) begin
      opt_q  <= wdata & IMPL_MSK;
      lock_q <= 1'b1;
    end
  end

  assign opt    = opt_q;
  assign locked = lock_q;
endmodule

// File: rtl/rst_cause_sysopt.sv
module rst_cause_sysopt
  import rcs_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16,
  parameter logic [7:0]  OPT_RESET = 8'hF3,
  parameter logic [7:0]  OPT_IMPL  = 8'hF3
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       clkgen_req,
  input  logic       lv_below,
  input  logic       lvd_en,
  input  logic       lvd_rst_en,
  input  logic       dbg_wr,
  input  logic       dbg_wbit,
  input  logic       cpu_sel,
  input  logic       cpu_wr,
  input  logic [1:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       sys_rst_req
);
  // named internal events for the checker
  rcs_cause_t  causes;
  logic        cause_any;
  logic        rst_hold;
  logic        opt_wr_en;
  logic [7:0]  status_q;
  logic [7:0]  opt_q;
  logic        lock_q;

  assign causes.clk = clkgen_req;
  assign causes.lv  = lv_trip(lv_below, lvd_en, lvd_rst_en);
  assign causes.dbg = dbg_wr & dbg_wbit;
  assign cause_any  = |causes;
  assign rst_hold   = cause_any | sys_rst_req;
  assign opt_wr_en  = cpu_sel & cpu_wr & (rcs_addr_e'(cpu_addr) == ADR_OPTS);

  rcs_pulse_stretch #(.LEN(PULSE_LEN)) u_stretch (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (cause_any),
    .active (sys_rst_req)
  );

  rcs_cause_latch u_cause (
    .clk      (clk),
    .por_n    (por_n),
    .causes   (causes),
    .in_reset (sys_rst_req),
    .status   (status_q)
  );

  rcs_opt_reg #(.RST_VAL(OPT_RESET), .IMPL_MSK(OPT_IMPL)) u_opt (
    .clk    (clk),
    .por_n  (por_n),
    .clear  (rst_hold),
    .wr_en  (opt_wr_en),
    .wdata  (cpu_wdata),
    .opt    (opt_q),
    .locked (lock_q)
  );

  always_comb begin
    unique case (rcs_addr_e'(cpu_addr))
      ADR_STATUS: cpu_rdata = status_q;
      ADR_OPTS:   cpu_rdata = opt_q;
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int unsigned PULSE_LEN = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       cause_any,
  input logic       sys_rst_req,
  input logic       lock_q,
  input logic [7:0] opt_q,
  input logic [7:0] status_q,
  input logic [1:0] cpu_addr,
  input logic [7:0] cpu_rdata,
  input logic       cpu_sel,
  input logic       cpu_wr,
  input logic       lv_below,
  input logic       lvd_en,
  input logic       lvd_rst_en
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_cnt <= '0;
    end else if (!sys_rst_req) begin
      hi_cnt <= '0;
    end else if (hi_cnt != HMAX) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R7: a request starts only after a cause and never ends early
  assert_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_req) |-> $past(cause_any));
  assert_min_width_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_req) |-> (hi_cnt >= HW'(PULSE_LEN)));
  assert_cause_raises_R7: assert property (@(posedge clk) disable iff (!por_n)
    cause_any |=> sys_rst_req);

  // R9: once locked and no reset around, the options value stays put
  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!por_n)
    (lock_q && !cause_any && !sys_rst_req) |=> $stable(opt_q));

  // R10: reset activity leaves options unlocked
  assert_reset_unlocks_R10: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> !lock_q);

  // R8: unimplemented options bits read 0
  assert_opt_gap_R8: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_addr == 2'd2) |-> (cpu_rdata[3:2] == 2'b00));

  // R5: force-reset location reads 0
  assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_addr == 2'd1) |-> (cpu_rdata == 8'h00));

  // R3: a partial low-voltage condition never starts a reset on its own
  assert_lv_gate_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_req && !cause_any && lv_below && !(lvd_en && lvd_rst_en)) |=> $stable(status_q));

  // R11: CPU write to status with no cause leaves it unchanged
  assert_status_ro_R11: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_sel && cpu_wr && cpu_addr == 2'd0 && !cause_any) |=> $stable(status_q));
endmodule

bind rst_cause_sysopt rcs_checker #(.PULSE_LEN(PULSE_LEN)) u_rcs_checker (
  .clk         (clk),
  .por_n       (por_n),
  .cause_any   (cause_any),
  .sys_rst_req (sys_rst_req),
  .lock_q      (lock_q),
  .opt_q       (opt_q),
  .status_q    (status_q),
  .cpu_addr    (cpu_addr),
  .cpu_rdata   (cpu_rdata),
  .cpu_sel     (cpu_sel),
  .cpu_wr      (cpu_wr),
  .lv_below    (lv_below),
  .lvd_en      (lvd_en),
  .lvd_rst_en  (lvd_rst_en)
);

// File: tb/rst_cause_sysopt_bench.sv
`timescale 1ns/1ps
module rst_cause_sysopt_bench;
  localparam int unsigned LEN = 16;
  localparam logic [7:0] IMPL = 8'hF3;
  localparam logic [7:0] DEF  = 8'hF3;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       clkgen_req = 1'b0, lv_below = 1'b0, lvd_en = 1'b0, lvd_rst_en = 1'b0;
  logic       dbg_wr = 1'b0, dbg_wbit = 1'b0;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       sys_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_sysopt u_rst_cause_sysopt (
    .clk(clk), .por_n(por_n), .clkgen_req(clkgen_req), .lv_below(lv_below),
    .lvd_en(lvd_en), .lvd_rst_en(lvd_rst_en), .dbg_wr(dbg_wr), .dbg_wbit(dbg_wbit),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] masked(input logic [7:0] v);
    return v & IMPL;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  // count samples with request high, starting at the current sample
  task automatic measure(output int n);
    n = 0;
    while (sys_rst_req) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clk_reset();
    clkgen_req = 1'b1;
    @(negedge clk);
    clkgen_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] d, prev;
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1: power-on status
    rd(2'd0, d); check("R1 por status", d, 8'h82);
    check("R7 req during por stretch", sys_rst_req, 1);
    measure(n); check("R7 por pulse length", n, LEN);
    // R8: default options
    rd(2'd2, d); check("R8 options default", d, DEF);

    // R2: clock cause overwrites
    clk_reset();
    check("R2 req raised", sys_rst_req, 1);
    rd(2'd0, d); check("R2 status clk only", d, 8'h04);
    measure(n); check("R7 clk pulse length", n, LEN);

    // R9/R10: sweep all write values
    for (int v = 0; v < 256; v++) begin
      clk_reset();
      measure(n);
      rd(2'd2, d); check("R10 options reset", d, DEF);
      wr(2'd2, 8'(v));
      rd(2'd2, d); check("R9 first write", d, masked(8'(v)));
      wr(2'd2, ~8'(v));
      rd(2'd2, d); check("R9 second write ignored", d, masked(8'(v)));
    end

    // R10: write during reset pulse ignored, first write after honoured
    clk_reset();
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R10 write in reset ignored", d, DEF);
    measure(n);
    wr(2'd2, 8'h5A);
    rd(2'd2, d); check("R10 write after reset", d, 8'h52);

    // R3: low-voltage gating sweep
    for (int i = 0; i < 8; i++) begin
      rd(2'd0, prev);
      lv_below = i[0]; lvd_en = i[1]; lvd_rst_en = i[2];
      @(negedge clk);
      lv_below = 1'b0; lvd_en = 1'b0; lvd_rst_en = 1'b0;
      check("R3 lv request", sys_rst_req, (i == 7) ? 1 : 0);
      rd(2'd0, d); check("R3 lv status", d, (i == 7) ? 8'h02 : prev);
      measure(n);
    end

    // R4: debug force
    dbg_wr = 1'b1; dbg_wbit = 1'b0;
    @(negedge clk);
    dbg_wr = 1'b0;
    check("R4 debug zero no reset", sys_rst_req, 0);
    rd(2'd0, d); check("R4 debug zero status", d, 8'h02);
    dbg_wr = 1'b1; dbg_wbit = 1'b1;
    @(negedge clk);
    dbg_wr = 1'b0; dbg_wbit = 1'b0;
    check("R4 debug one reset", sys_rst_req, 1);
    rd(2'd0, d); check("R4 debug status", d, 8'h08);
    measure(n);

    // R5: CPU write to force location
    wr(2'd1, 8'hFF);
    check("R5 cpu force ignored", sys_rst_req, 0);
    rd(2'd1, d); check("R5 force reads zero", d, 8'h00);
    rd(2'd0, d); check("R5 status unchanged", d, 8'h08);

    // R11: status read-only
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R11 status read only", d, 8'h08);
    rd(2'd3, d); check("R5 unused address zero", d, 8'h00);

    // R6: simultaneous causes
    clkgen_req = 1'b1; dbg_wr = 1'b1; dbg_wbit = 1'b1;
    @(negedge clk);
    clkgen_req = 1'b0; dbg_wr = 1'b0; dbg_wbit = 1'b0;
    rd(2'd0, d); check("R6 simultaneous", d, 8'h0C);
    measure(n);

    // R6/R7: cause during pulse merges and extends
    clk_reset();
    repeat (5) @(negedge clk);
    lv_below = 1'b1; lvd_en = 1'b1; lvd_rst_en = 1'b1;
    @(negedge clk);
    lv_below = 1'b0; lvd_en = 1'b0; lvd_rst_en = 1'b0;
    rd(2'd0, d); check("R6 merged during reset", d, 8'h06);
    measure(n); check("R7 extended length", n, LEN);

    finish_run();
  end
endmodule